// File: doc/BRIEF.md
# Keypad Line-to-Code Converter

A twelve-key telephone-style keypad, laid out as four rows of three keys, reports a press by raising one row line and one column line at once. This block takes those seven active-high lines and turns them into a 4-bit key code that downstream logic can use directly. The ten digits appear as their own binary values, the star and hash keys get two dedicated codes above nine, and the all-quiet keypad gives the code 1111.

The converter is purely combinational, with no clock and no reset. It treats any pattern that cannot come from a single clean press as idle: two rows, two columns, a row with no column, or a column with no row. A separate valid flag goes high only for a clean single press. Scanning, debouncing and multi-key history belong to other blocks.

Top module: `kp_code_conv`

## Requirements
- R1: `key_valid` is 1 exactly when one bit of `row_lines` and one bit of `col_lines` are set, and 0 for every other pattern.
- R2: With one row among the top three (`row_lines` bit 0, 1 or 2) and one column set, `key_code` equals 3*row + col + 1, where row and col are the set bit positions. Bit 0 is the top row or the left column. The result is the digits 1 to 9.
- R3: Bottom row (`row_lines` bit 3) with the middle column (`col_lines` bit 1) gives 0000. Row bit 1 with column bit 1 gives 0101.
- R4: Bottom row with the left column (`col_lines` bit 0) is the star key and gives 1010.
- R5: Bottom row with the right column (`col_lines` bit 2) is the hash key and gives 1011.
- R6: All seven lines low gives `key_code` 1111 and `key_valid` 0.
- R7: Any pattern with two or more rows, two or more columns, a row without a column, or a column without a row gives `key_code` 1111.
- R8: `key_code` never takes the values 1100, 1101 or 1110.
- R9: `key_code` is 1111 exactly when `key_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| row_lines | input | 4 | Row lines, bit 0 top row to bit 3 bottom row, active high |
| col_lines | input | 3 | Column lines, bit 0 left to bit 2 right, active high |
| key_code | output | 4 | Key code: digits 0000-1001, star 1010, hash 1011, idle 1111 |
| key_valid | output | 1 | High only for exactly one row and exactly one column |

## Verification
The hardest cases to reach are the degenerate patterns that sit next to legal presses. Examples are a legal row and column with one more line set, or a lone line with its partner missing. These cases must fall to idle rather than decode as a nearby key. The stimulus reaches them by sweeping all 128 line combinations. It compares each one with a bench-side key table built from the keypad layout, and directed tasks first target star, hash, zero and the two-line faults.

// File: rtl/kp_pkg.sv
package kp_pkg;
    localparam int KP_ROWS   = 4;
    localparam int KP_COLS   = 3;
    localparam int KP_CODE_W = 4;

    localparam logic [KP_CODE_W-1:0] CODE_ZERO = 4'b0000;
    localparam logic [KP_CODE_W-1:0] CODE_STAR = 4'b1010;
    localparam logic [KP_CODE_W-1:0] CODE_HASH = 4'b1011;
    localparam logic [KP_CODE_W-1:0] CODE_IDLE = 4'b1111;

    typedef enum logic [1:0] {
        BOT_LEFT  = 2'd0,
        BOT_MID   = 2'd1,
        BOT_RIGHT = 2'd2
    } bot_col_e;
endpackage

// File: rtl/kp_onehot_enc.sv
module kp_onehot_enc #(
    parameter int WIDTH = 4,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] lines,
    output logic             single,
    output logic [IDX_W-1:0] index
);
    logic [WIDTH:0] seen_one;
    logic [WIDTH:0] seen_two;
    logic [IDX_W-1:0] idx_part [WIDTH+1];

    assign seen_one[0] = 1'b0;
    assign seen_two[0] = 1'b0;
    assign idx_part[0] = '0;

    for (genvar g = 0; g < WIDTH; g++) begin : g_scan
        assign seen_two[g+1] = seen_two[g] | (seen_one[g] & lines[g]);
        assign seen_one[g+1] = seen_one[g] | lines[g];
        assign idx_part[g+1] = lines[g] ? IDX_W'(g) : idx_part[g];
    end

    assign single = seen_one[WIDTH] & ~seen_two[WIDTH];
    assign index  = idx_part[WIDTH];

    // R1
    always_comb begin
        single_count_chk: assert (single == ($countones(lines) == 1));
    end
endmodule

// File: rtl/kp_code_map.sv
module kp_code_map
    import kp_pkg::*;
#(
    parameter int NUM_ROWS = KP_ROWS,
    parameter int NUM_COLS = KP_COLS,
    parameter int CODE_W   = KP_CODE_W,
    localparam int ROW_W = $clog2(NUM_ROWS),
    localparam int COL_W = $clog2(NUM_COLS)
) (
    input  logic              press_ok,
    input  logic [ROW_W-1:0]  row_idx,
    input  logic [COL_W-1:0]  col_idx,
    output logic [CODE_W-1:0] code
);
    localparam int LAST_ROW = NUM_ROWS - 1;

    always_comb begin
        code = CODE_IDLE;
        if (press_ok) begin
            if (int'(row_idx) < LAST_ROW) begin
                code = CODE_W'(int'(row_idx) * NUM_COLS + int'(col_idx) + 1);
            end else begin
                unique case (bot_col_e'(col_idx))
                    BOT_LEFT:  code = CODE_STAR;
                    BOT_MID:   code = CODE_ZERO;
                    BOT_RIGHT: code = CODE_HASH;
                    default:   code = CODE_IDLE;
                endcase
            end
        end
    end

    // R8
    always_comb begin
        code_range_chk: assert (!(code inside {4'b1100, 4'b1101, 4'b1110}));
    end
endmodule

// File: rtl/kp_code_conv.sv
module kp_code_conv
    import kp_pkg::*;
#(
    parameter int NUM_ROWS = KP_ROWS,
    parameter int NUM_COLS = KP_COLS,
    parameter int CODE_W   = KP_CODE_W,
    localparam int ROW_W = $clog2(NUM_ROWS),
    localparam int COL_W = $clog2(NUM_COLS)
) (
    input  logic [NUM_ROWS-1:0] row_lines,
    input  logic [NUM_COLS-1:0] col_lines,
    output logic [CODE_W-1:0]   key_code,
    output logic                key_valid
);
    logic             row_single;
    logic             col_single;
    logic [ROW_W-1:0] row_idx;
    logic [COL_W-1:0] col_idx;

    kp_onehot_enc #(.WIDTH(NUM_ROWS)) u_row_enc (
        .lines  (row_lines),
        .single (row_single),
        .index  (row_idx)
    );

    kp_onehot_enc #(.WIDTH(NUM_COLS)) u_col_enc (
        .lines  (col_lines),
        .single (col_single),
        .index  (col_idx)
    );

    assign key_valid = row_single & col_single;

    kp_code_map #(
        .NUM_ROWS (NUM_ROWS),
        .NUM_COLS (NUM_COLS),
        .CODE_W   (CODE_W)
    ) u_map (
        .press_ok (key_valid),
        .row_idx  (row_idx),
        .col_idx  (col_idx),
        .code     (key_code)
    );

    always_comb begin
        // R9
        idle_match_chk: assert ((key_code == CODE_IDLE) == !key_valid);
        // R6
        quiet_idle_chk: assert (!((row_lines == '0) && (col_lines == '0)) || (key_code == CODE_IDLE));
        // R7
        multi_line_chk: assert (!(($countones(row_lines) > 1) || ($countones(col_lines) > 1)) || !key_valid);
    end
endmodule

// File: tb/tb_kp_code_conv.sv
module tb_kp_code_conv;
    logic       clk = 1'b0;
    logic [3:0] row_lines;
    logic [2:0] col_lines;
    logic [3:0] key_code;
    logic       key_valid;
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         done     = 1'b0;

    always #4 clk = ~clk;

    kp_code_conv dut (
        .row_lines (row_lines),
        .col_lines (col_lines),
        .key_code  (key_code),
        .key_valid (key_valid)
    );

    function automatic logic [3:0] key_of(input int pos);
        case (pos)
            0: return 4'd1;  1: return 4'd2;  2: return 4'd3;
            3: return 4'd4;  4: return 4'd5;  5: return 4'd6;
            6: return 4'd7;  7: return 4'd8;  8: return 4'd9;
            9: return 4'b1010; 10: return 4'd0; 11: return 4'b1011;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic apply_check(input logic [3:0] r, input logic [2:0] c,
                               input logic [3:0] exp_code, input logic exp_valid,
                               input string req);
        @(posedge clk);
        row_lines = r;
        col_lines = c;
        @(negedge clk);
        n_checks++;
        if (key_code !== exp_code || key_valid !== exp_valid) begin
            n_fail++;
            $display("FAIL %s rows=%b cols=%b: code=%b valid=%b expected code=%b valid=%b",
                     req, r, c, key_code, key_valid, exp_code, exp_valid);
        end
    endtask

    task automatic test_idle();
        apply_check(4'b0000, 3'b000, 4'b1111, 1'b0, "R6");
    endtask

    task automatic test_special();
        apply_check(4'b1000, 3'b010, 4'b0000, 1'b1, "R3");
        apply_check(4'b0010, 3'b010, 4'b0101, 1'b1, "R3");
        apply_check(4'b1000, 3'b001, 4'b1010, 1'b1, "R4");
        apply_check(4'b1000, 3'b100, 4'b1011, 1'b1, "R5");
        apply_check(4'b0001, 3'b001, 4'b0001, 1'b1, "R2");
        apply_check(4'b0100, 3'b100, 4'b1001, 1'b1, "R2");
    endtask

    task automatic test_faults();
        apply_check(4'b0011, 3'b001, 4'b1111, 1'b0, "R7");
        apply_check(4'b0010, 3'b011, 4'b1111, 1'b0, "R7");
        apply_check(4'b1000, 3'b000, 4'b1111, 1'b0, "R7");
        apply_check(4'b0000, 3'b100, 4'b1111, 1'b0, "R7");
        apply_check(4'b1111, 3'b111, 4'b1111, 1'b0, "R7");
    endtask

    // R1 R2 R8 R9: every line combination against the bench key table
    task automatic test_sweep();
        for (int p = 0; p < 128; p++) begin
            logic [3:0] r = p[6:3];
            logic [2:0] c = p[2:0];
            int nr = 0, nc = 0, ri = 0, ci = 0;
            for (int i = 0; i < 4; i++) if (r[i]) begin nr++; ri = i; end
            for (int j = 0; j < 3; j++) if (c[j]) begin nc++; ci = j; end
            if (nr == 1 && nc == 1)
                apply_check(r, c, key_of(ri * 3 + ci), 1'b1, "R1/R2");
            else
                apply_check(r, c, 4'b1111, 1'b0, "R1/R9");
            n_checks++;
            if (key_code inside {4'b1100, 4'b1101, 4'b1110}) begin
                n_fail++;
                $display("FAIL R8 code=%b expected outside 1100..1110", key_code);
            end
        end
    endtask

    initial begin
        row_lines = '0;
        col_lines = '0;
        test_idle();
        test_special();
        test_faults();
        test_sweep();
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 100000 && !done; k++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule